// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps time of day and calendar in a set of running BCD counters: seconds, minutes, hours, day of week, date, month and two-digit year. A one-pulse-per-second tick input advances them. Software never touches the running counters directly. It sees a second, double-buffered set of user copies through a small synchronous register bus that has an address, write data, a write strobe, a read strobe and registered read data.

Two freeze bits in a control byte set how the two copies move. One cycle after each tick, every user copy takes the counter values together, in a single cycle. The read-freeze bit stops that refresh so software can read a time that holds still while the counters keep running. The write-freeze bit also stops the refresh, and it opens the time registers for writing. Clearing the write-freeze bit loads every user copy back into the counters at once. A stop bit at the top of the seconds byte halts all counting.

Top module: `rtc_bank`

## Requirements
- R1: After reset, reads return control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01 and year 0x00.
- R2: The address map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. A read strobe loads the addressed byte into the read data on the next clock edge. The read data holds its value while the read strobe is low.
- R3: While no freeze bit is set, each tick advances the counters by one second with BCD carries. On the next cycle, all seven user copies take the counter values together.
- R4: Seconds and minutes wrap 59 to 00. Hours wrap 23 to 00. At midnight the day of week steps, wrapping 07 to 01. Month wraps 12 to 01 and increments the year. Year wraps 99 to 00.
- R5: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02, 29 when the year value is divisible by 4 and 28 otherwise.
- R6: While control bit 6 (read freeze) is set, the user copies do not change but the counters keep counting. Once the bit is cleared, the next tick shows the current time.
- R7: When a control write sets a freeze bit in the cycle right after a tick, that tick's refresh still takes place. The frozen copies then hold the updated time.
- R8: While control bit 7 (write freeze) is set, refreshes are blocked and writes to addresses 1 to 7 update the user copies at once. While bit 7 is clear, writes to addresses 1 to 7 are ignored.
- R9: A control write that clears bit 7 while it is set loads all seven user copies into the counters. The next tick shows the loaded time plus one second.
- R10: Seconds bit 7 is the stop bit. While the stop bit is set in the counters, ticks leave every counter unchanged.
- R11: Control bits 5..0 and the bits above each time field (minutes bit 7, hours and date bits 7..6, day bits 7..3, month bits 7..5) are plain storage. They read back as written and are never changed by counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach is a freeze that lands in the exact cycle of a refresh. The bench pulses the tick and issues the control write on the very next clock edge. It then shows that the frozen value is the one after the tick and not the one before. Month-end and leap-year corners need the time to be loaded first. The bench commits a chosen moment (23:59:59 on the last day, or the day before it) for every month across several leap and non-leap years, then ticks once. A long run of several thousand ticks crosses a leap day, midnight and an hour boundary, and an arithmetic model in the bench checks every step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = $clog2(NUM_FIELDS + 1);

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_WDAY  = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  localparam int WFRZ_BIT = 7;
  localparam int RFRZ_BIT = 6;
  localparam int STOP_BIT = 7;

  typedef logic [BYTE_W-1:0] bcd_byte_t;

  function automatic bcd_byte_t field_mask(int idx);
    case (idx)
      F_SEC, F_MIN:   return 8'h7F;
      F_HOUR, F_DATE: return 8'h3F;
      F_WDAY:         return 8'h07;
      F_MONTH:        return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic bcd_byte_t reset_value(int idx);
    case (idx)
      F_WDAY, F_DATE, F_MONTH: return 8'h01;
      default:                 return 8'h00;
    endcase
  endfunction

  function automatic bcd_byte_t bcd_inc(bcd_byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(bcd_byte_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd_byte_t month_len(bcd_byte_t m, bcd_byte_t y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
#(
  parameter int NF = NUM_FIELDS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  load,
  input  logic [NF-1:0][7:0]    load_val,
  output logic [NF-1:0][7:0]    cnt_q
);
  logic [NF-1:0][7:0] fld, hi, lo, stepped, nxt;
  logic [NF-1:0]      wrap, en;

  always_comb begin
    for (int i = 0; i < NF; i++) fld[i] = cnt_q[i] & field_mask(i);
    hi = '0;
    lo = '0;
    hi[F_SEC]   = 8'h59; lo[F_SEC]   = 8'h00;
    hi[F_MIN]   = 8'h59; lo[F_MIN]   = 8'h00;
    hi[F_HOUR]  = 8'h23; lo[F_HOUR]  = 8'h00;
    hi[F_WDAY]  = 8'h07; lo[F_WDAY]  = 8'h01;
    hi[F_DATE]  = month_len(fld[F_MONTH], fld[F_YEAR]);
    lo[F_DATE]  = 8'h01;
    hi[F_MONTH] = 8'h12; lo[F_MONTH] = 8'h01;
    hi[F_YEAR]  = 8'h99; lo[F_YEAR]  = 8'h00;
  end

  // carry chain: day of week is a side branch of the midnight carry
  always_comb begin
    en = '0;
    en[F_SEC]   = tick && !cnt_q[F_SEC][STOP_BIT];
    en[F_MIN]   = en[F_SEC]  && wrap[F_SEC];
    en[F_HOUR]  = en[F_MIN]  && wrap[F_MIN];
    en[F_WDAY]  = en[F_HOUR] && wrap[F_HOUR];
    en[F_DATE]  = en[F_HOUR] && wrap[F_HOUR];
    en[F_MONTH] = en[F_DATE] && wrap[F_DATE];
    en[F_YEAR]  = en[F_MONTH] && wrap[F_MONTH];
  end

  for (genvar g = 0; g < NF; g++) begin : g_field
    assign wrap[g]    = (fld[g] >= hi[g]);
    assign stepped[g] = (wrap[g] ? lo[g] : bcd_inc(fld[g])) & field_mask(g);
    assign nxt[g]     = en[g] ? ((cnt_q[g] & ~field_mask(g)) | stepped[g]) : cnt_q[g];

    always_ff @(posedge clk) begin
      if (rst)       cnt_q[g] <= reset_value(g);
      else if (load) cnt_q[g] <= load_val[g];
      else           cnt_q[g] <= nxt[g];
    end
  end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int AW = ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refresh,
  input  logic [NF-1:0][7:0] src,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  output logic [NF-1:0][7:0] usr_q
);
  for (genvar g = 0; g < NF; g++) begin : g_copy
    localparam logic [AW-1:0] MY_ADDR = AW'(g + 1);
    always_ff @(posedge clk) begin
      if (rst)                               usr_q[g] <= reset_value(g);
      else if (refresh)                      usr_q[g] <= src[g];
      else if (wr_en && wr_addr == MY_ADDR)  usr_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/rtc_bank.sv
module rtc_bank
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata
);
  localparam int NF = NUM_FIELDS;

  logic [7:0]         ctrl_q;
  logic               tick_d;
  logic               ctrl_wr, time_wr, refresh, commit;
  logic [NF-1:0][7:0] cnt, usr;

  assign ctrl_wr = bus_we && (bus_addr == '0);
  assign time_wr = bus_we && (bus_addr != '0) && ctrl_q[WFRZ_BIT];
  assign refresh = tick_d && !ctrl_q[WFRZ_BIT] && !ctrl_q[RFRZ_BIT];
  assign commit  = ctrl_wr && ctrl_q[WFRZ_BIT] && !bus_wdata[WFRZ_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tick_d <= 1'b0;
    end else begin
      tick_d <= tick_1hz;
      if (ctrl_wr) ctrl_q <= bus_wdata;
    end
  end

  rtc_counter #(.NF(NF)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1hz),
    .load     (commit),
    .load_val (usr),
    .cnt_q    (cnt)
  );

  rtc_shadow #(.NF(NF), .AW(ADDR_W)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .refresh (refresh),
    .src     (cnt),
    .wr_en   (time_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .usr_q   (usr)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) begin
      if (bus_addr == '0) bus_rdata <= ctrl_q;
      else                bus_rdata <= usr[bus_addr - ADDR_W'(1)];
    end
  end
endmodule

// File: rtl/rtc_bank_checker.sv
module rtc_bank_checker (
  input logic        clk,
  input logic        rst,
  input logic        re,
  input logic [7:0]  rdata,
  input logic [7:0]  ctrl,
  input logic        refresh,
  input logic        commit,
  input logic        time_wr,
  input logic [55:0] cnt,
  input logic [55:0] usr
);
  // R2: read data holds while no read strobe
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

  // R3: a refresh copies every counter in one cycle
  assert_refresh_copy_R3: assert property (@(posedge clk) disable iff (rst)
    refresh |=> (usr == $past(cnt)));

  // R6: read freeze alone keeps the user copies still
  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl[6] && !ctrl[7]) |=> $stable(usr));

  // R8: user copies unchanged without refresh or an accepted write
  assert_ignored_write_R8: assert property (@(posedge clk) disable iff (rst)
    (!refresh && !time_wr) |=> $stable(usr));

  // R9: commit loads every user copy into the counters
  assert_commit_load_R9: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cnt == $past(usr)));

  // R10: stop bit holds all counters
  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt[7] && !commit) |=> $stable(cnt));
endmodule

bind rtc_bank rtc_bank_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .re      (bus_re),
  .rdata   (bus_rdata),
  .ctrl    (ctrl_q),
  .refresh (refresh),
  .commit  (commit),
  .time_wr (time_wr),
  .cnt     (cnt),
  .usr     (usr)
);

// File: tb/rtc_bank_bench.sv
module rtc_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  int m_s, m_mi, m_h, m_dw, m_d, m_mo, m_y;
  bit m_stop;

  rtc_bank u_rtc_bank (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done) begin
      nfail = nfail + 1;
      $display("FAIL watchdog R3 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [7:0] to_bcd(int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = 3'(a);
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic model_tick();
    if (m_stop) return;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_dw = (m_dw == 7) ? 1 : m_dw + 1;
          m_d++;
          if (m_d > mlen(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [7:0] v;
    rd(1, v); chk({tag, " sec"},   v, to_bcd(m_s) | {m_stop, 7'h0});
    rd(2, v); chk({tag, " min"},   v, to_bcd(m_mi));
    rd(3, v); chk({tag, " hour"},  v, to_bcd(m_h));
    rd(4, v); chk({tag, " wday"},  v, to_bcd(m_dw));
    rd(5, v); chk({tag, " date"},  v, to_bcd(m_d));
    rd(6, v); chk({tag, " month"}, v, to_bcd(m_mo));
    rd(7, v); chk({tag, " year"},  v, to_bcd(m_y));
  endtask

  task automatic set_time(int y, int mo, int d, int dw, int h, int mi, int s);
    wr(0, 8'h80);
    wr(1, to_bcd(s));  wr(2, to_bcd(mi)); wr(3, to_bcd(h)); wr(4, to_bcd(dw));
    wr(5, to_bcd(d));  wr(6, to_bcd(mo)); wr(7, to_bcd(y));
    wr(0, 8'h00);
    m_y = y; m_mo = mo; m_d = d; m_dw = dw; m_h = h; m_mi = mi; m_s = s; m_stop = 0;
  endtask

  initial begin
    logic [7:0] v;
    int ys[7] = '{0, 1, 2, 3, 4, 96, 99};
    m_s = 0; m_mi = 0; m_h = 0; m_dw = 1; m_d = 1; m_mo = 1; m_y = 0; m_stop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    check_all("R1");

    // R2 read data holds without a strobe
    rd(4, v); chk("R2 wday", v, 8'h01);
    do_tick(); model_tick();
    chk("R2 hold", bus_rdata, 8'h01);

    // R3 counting with carries
    check_all("R3 first");
    for (int i = 0; i < 125; i++) begin do_tick(); model_tick(); end
    check_all("R3 carry");

    // R11 storage bits
    wr(0, 8'h2A); rd(0, v); chk("R11 ctrl", v, 8'h2A);
    wr(0, 8'h00);
    wr(0, 8'h80); wr(6, 8'hA0 | to_bcd(m_mo)); wr(2, 8'h80 | to_bcd(m_mi)); wr(0, 8'h00);
    do_tick(); model_tick();
    rd(6, v); chk("R11 month", v, 8'hA0 | to_bcd(m_mo));
    rd(2, v); chk("R11 min",   v, 8'h80 | to_bcd(m_mi));

    // R8 ignored writes while write bit clear
    set_time(10, 5, 10, 3, 12, 30, 20);
    wr(1, 8'h33); wr(5, 8'h07);
    check_all("R8 ignored");
    // R8 write bit set: writes visible, refresh blocked
    wr(0, 8'h80); wr(1, 8'h45);
    rd(1, v); chk("R8 wr visible", v, 8'h45);
    do_tick();
    rd(1, v); chk("R8 refresh blocked", v, 8'h45);
    // R9 commit loads copies
    wr(0, 8'h00); m_s = 45;
    check_all("R9 before tick");
    do_tick(); model_tick();
    check_all("R9 loaded+1");

    // R6 read freeze
    wr(0, 8'h40);
    for (int i = 0; i < 5; i++) do_tick();
    check_all("R6 frozen");
    for (int i = 0; i < 5; i++) model_tick();
    wr(0, 8'h00);
    do_tick(); model_tick();
    check_all("R6 resumed");

    // R7 freeze in the refresh cycle
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h40;
    @(negedge clk); bus_we = 1'b0;
    model_tick();
    do_tick(); do_tick();
    check_all("R7 refresh first");
    model_tick(); model_tick();
    wr(0, 8'h00);
    do_tick(); model_tick();
    check_all("R7 resumed");

    // R10 stop bit
    wr(0, 8'h80); wr(1, 8'h90); wr(0, 8'h00); m_s = 10; m_stop = 1;
    for (int i = 0; i < 3; i++) begin do_tick(); model_tick(); end
    check_all("R10 stopped");
    wr(0, 8'h80); wr(1, 8'h10); wr(0, 8'h00); m_s = 10; m_stop = 0;
    do_tick(); model_tick();
    check_all("R10 running");

    // R4 R5 month ends across years
    foreach (ys[k]) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_time(ys[k], mo, mlen(mo, ys[k]) - 1, (mo % 7) + 1, 23, 59, 59);
        do_tick(); model_tick();
        check_all("R5 day before end");
        set_time(ys[k], mo, mlen(mo, ys[k]), (mo == 7) ? 7 : (mo % 7) + 1, 23, 59, 59);
        do_tick(); model_tick();
        check_all("R4 R5 month end");
      end
    end

    // R4 long run across leap day, midnight and hour
    set_time(24, 2, 28, 7, 23, 59, 30);
    for (int i = 0; i < 3700; i++) begin
      do_tick(); model_tick();
      if (i % 4 == 0 || i < 40) check_all("R4 run");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule